// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block is a purely combinational adder and subtractor for two unsigned operands of a parameterised width, 16 bits by default. Every bit forms its own generate term (both operand bits set) and propagate term (either operand bit set). The bits are gathered into groups of four. Each group works out the carries into its four bits as flat sum-of-products expressions and reports a group generate and a group propagate. A second lookahead level combines those group terms with the external carry-in to produce the carry into every group at once, so the carry path never ripples from one group into the next.

A subtract control turns the block into A minus B: the B operand is inverted and the carry-in is forced to one, so the carry-in pin has no effect in that mode. The carry-out then means that no borrow occurred. A single flag reports two's-complement overflow for the operation performed. The block has no clock and no state. Its operands and results are plain control-free data pins, so it is dropped straight into a surrounding datapath stage, and that stage's registers own any handshake.

Top module: `cla_adder`

## Requirements
- R1: With sub_en at 0, {carry_out, result} equals opa + opb + carry_in computed at WIDTH+1 bits.
- R2: With opa all ones, opb zero, carry_in 1 and sub_en 0, the result is zero and carry_out is 1: a carry born below the lowest group reaches the top output.
- R3: With sub_en at 1, result equals (opa - opb) modulo 2^WIDTH whatever the value of carry_in.
- R4: With sub_en at 1, carry_out is 1 exactly when opa >= opb taken as unsigned numbers (no borrow).
- R5: overflow is 1 exactly when the operation performed, read as signed two's-complement, gives a result whose sign cannot hold the true value: for addition the operand signs match and the result sign differs; for subtraction the operand signs differ and the result sign differs from opa.
- R6: With both operands zero, carry_in 0 and sub_en 0, result, carry_out and overflow are all 0.
- R7: With both operands all ones and carry_in 1 in add mode, result is all ones and carry_out is 1: each sum bit uses the exclusive OR of the operand bits, not the propagate term.
- R8: WIDTH is a multiple of 4; each group of four bits and the group-level carries follow the same lookahead form, so the result is correct at widths 8 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, inverted internally when subtracting |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored when subtracting |
| sub_en | input | 1 | 1 selects opa - opb, 0 selects opa + opb + carry_in |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top group; in subtract mode 1 means no borrow |
| overflow | output | 1 | Signed overflow of the operation performed |

## Verification
The two functions that coincide are the forced carry-in of subtraction and the group-level lookahead that must carry it across every group in the same evaluation. An eight-bit instance is swept over every operand pair in both modes with both carry-in values, so a subtraction whose inverted B operand is all ones propagates the forced carry through all groups while the carry-in pin toggles and must change nothing. Each case is judged against arithmetic done on wider integers in the bench, for result, carry-out and overflow together, and the 16-bit default instance is hit with the all-ones, zero and long-propagate corners plus a pseudo-random walk.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Number of bits that one lookahead group covers.
  localparam int unsigned GRP_BITS = 4;

  // Number of groups for a given operand width.
  function automatic int unsigned grp_count(input int unsigned width);
    return width / GRP_BITS;
  endfunction

endpackage

// File: rtl/cla_bit_terms.sv
// Per-bit generate, propagate (inclusive OR) and half-sum terms.
module cla_bit_terms #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] half
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign gen[i]  = op_x[i] & op_y[i];
      assign prop[i] = op_x[i] | op_y[i];
      assign half[i] = op_x[i] ^ op_y[i];
    end
  endgenerate

endmodule

// File: rtl/cla_group4.sv
// One four-bit lookahead generator: flat carries into bits 1..3 and the
// group generate / propagate pair handed to the upper level.
module cla_group4 (
  input  logic [3:0] gen,
  input  logic [3:0] prop,
  input  logic       c_base,
  output logic [3:0] c_bits,
  output logic       grp_gen,
  output logic       grp_prop
);

  always_comb begin
    c_bits[0] = c_base;
    c_bits[1] = gen[0] | (prop[0] & c_base);
    c_bits[2] = gen[1]
              | (prop[1] & gen[0])
              | (prop[1] & prop[0] & c_base);
    c_bits[3] = gen[2]
              | (prop[2] & gen[1])
              | (prop[2] & prop[1] & gen[0])
              | (prop[2] & prop[1] & prop[0] & c_base);
  end

  assign grp_gen = gen[3]
                 | (prop[3] & gen[2])
                 | (prop[3] & prop[2] & gen[1])
                 | (prop[3] & prop[2] & prop[1] & gen[0]);

  assign grp_prop = prop[3] & prop[2] & prop[1] & prop[0];

endmodule

// File: rtl/cla_upper.sv
// Second lookahead level: carry into every group as a flat OR of products
// of group terms and the external carry, no chaining between groups.
module cla_upper #(
  parameter int unsigned NGRP = 4
) (
  input  logic [NGRP-1:0] grp_gen,
  input  logic [NGRP-1:0] grp_prop,
  input  logic            c_ext,
  output logic [NGRP:0]   grp_carry
);

  always_comb begin
    grp_carry[0] = c_ext;
    for (int k = 1; k <= NGRP; k++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = grp_gen[j];
        for (int m = j + 1; m < k; m++) begin
          term = term & grp_prop[m];
        end
        acc = acc | term;
      end
      term = c_ext;
      for (int m = 0; m < k; m++) begin
        term = term & grp_prop[m];
      end
      grp_carry[k] = acc | term;
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  input  logic             sub_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);

  import cla_pkg::*;

  localparam int unsigned NGRP = grp_count(WIDTH);

  logic [WIDTH-1:0] opb_eff;
  logic             c_first;
  logic [WIDTH-1:0] gen, prop, half;
  logic [WIDTH-1:0] bit_carry;
  logic [NGRP-1:0]  grp_gen, grp_prop;
  logic [NGRP:0]    grp_carry;

  assign opb_eff = sub_en ? ~opb : opb;
  assign c_first = sub_en | carry_in;

  cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .op_x (opa),
    .op_y (opb_eff),
    .gen  (gen),
    .prop (prop),
    .half (half)
  );

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      cla_group4 u_grp (
        .gen      (gen [g*GRP_BITS +: GRP_BITS]),
        .prop     (prop[g*GRP_BITS +: GRP_BITS]),
        .c_base   (grp_carry[g]),
        .c_bits   (bit_carry[g*GRP_BITS +: GRP_BITS]),
        .grp_gen  (grp_gen[g]),
        .grp_prop (grp_prop[g])
      );
    end
  endgenerate

  cla_upper #(.NGRP(NGRP)) u_upper (
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .c_ext     (c_first),
    .grp_carry (grp_carry)
  );

  assign result    = half ^ bit_carry;
  assign carry_out = grp_carry[NGRP];
  assign overflow  = bit_carry[WIDTH-1] ^ grp_carry[NGRP];

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             carry_in,
  input logic             sub_en,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow
);

  logic [WIDTH:0] ref_add;
  logic [WIDTH-1:0] ref_dif;
  logic ref_ovf;

  always_comb begin
    ref_add = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
    ref_dif = opa - opb;
    if (sub_en)
      ref_ovf = (opa[WIDTH-1] != opb[WIDTH-1]) && (ref_dif[WIDTH-1] != opa[WIDTH-1]);
    else
      ref_ovf = (opa[WIDTH-1] == opb[WIDTH-1]) && (ref_add[WIDTH-1] != opa[WIDTH-1]);

    if (!sub_en) begin
      a_r1_add_matches: assert ({carry_out, result} == ref_add)
        else $error("R1 add mismatch");
    end
    if (sub_en) begin
      a_r3_sub_matches: assert (result == ref_dif)
        else $error("R3 subtract mismatch");
      a_r4_no_borrow: assert (carry_out == (opa >= opb))
        else $error("R4 borrow mismatch");
    end
    a_r5_signed_ovf: assert (overflow == ref_ovf)
      else $error("R5 overflow mismatch");
  end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_adder_test.sv
`timescale 1ns/1ps
module cla_adder_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Default 16-bit instance.
  logic [15:0] a16, b16, r16;
  logic        ci16, s16, co16, ov16;
  cla_adder #(.WIDTH(16)) uut (
    .opa(a16), .opb(b16), .carry_in(ci16), .sub_en(s16),
    .result(r16), .carry_out(co16), .overflow(ov16)
  );

  // Small instance for the exhaustive sweep.
  logic [7:0] a8, b8, r8;
  logic       ci8, s8, co8, ov8;
  cla_adder #(.WIDTH(8)) uut8 (
    .opa(a8), .opb(b8), .carry_in(ci8), .sub_en(s8),
    .result(r8), .carry_out(co8), .overflow(ov8)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arithmetic reference on wide integers.
  task automatic run16(input int a, input int b, input int ci, input int s);
    longint full, res, co, ov;
    longint sa, sb, sr;
    a16 = a[15:0]; b16 = b[15:0]; ci16 = ci[0]; s16 = s[0];
    #2;
    sa = (a >= 32768) ? a - 65536 : a;
    sb = (b >= 32768) ? b - 65536 : b;
    if (s != 0) begin
      full = a - b;
      res  = full & 16'hFFFF;
      co   = (a >= b) ? 1 : 0;
      sr   = sa - sb;
    end else begin
      full = a + b + ci;
      res  = full & 16'hFFFF;
      co   = full >> 16;
      sr   = sa + sb + ci;
    end
    ov = (sr > 32767 || sr < -32768) ? 1 : 0;
    chk((s != 0) ? "R3 result16" : "R1 result16", r16, res);
    chk((s != 0) ? "R4 carry16" : "R1 carry16", co16, co);
    chk("R5 overflow16", ov16, ov);
    #1;
  endtask

  initial begin
    a16 = '0; b16 = '0; ci16 = 1'b0; s16 = 1'b0;
    a8 = '0; b8 = '0; ci8 = 1'b0; s8 = 1'b0;
    repeat (2) @(negedge clk);

    // R6: idle operands.
    #1;
    chk("R6 zero result", r16, 0);
    chk("R6 zero carry", co16, 0);
    chk("R6 zero overflow", ov16, 0);

    // R2: carry from carry_in travels through every group.
    a16 = 16'hFFFF; b16 = 16'h0000; ci16 = 1'b1; s16 = 1'b0;
    #2;
    chk("R2 wrap result", r16, 0);
    chk("R2 wrap carry", co16, 1);

    // R7: both all ones with carry in.
    a16 = 16'hFFFF; b16 = 16'hFFFF; ci16 = 1'b1; s16 = 1'b0;
    #2;
    chk("R7 ones result", r16, 16'hFFFF);
    chk("R7 ones carry", co16, 1);

    // R3: carry_in has no effect when subtracting.
    a16 = 16'h1234; b16 = 16'h0F0F; s16 = 1'b1; ci16 = 1'b0;
    #2;
    chk("R3 sub ci=0", r16, 16'h0325);
    ci16 = 1'b1;
    #2;
    chk("R3 sub ci=1", r16, 16'h0325);

    // R4 / R5 corners on the default width.
    run16(0, 1, 0, 1);
    run16(16'h8000, 1, 0, 1);
    run16(16'h7FFF, 1, 0, 0);
    run16(16'h8000, 16'h8000, 0, 0);
    run16(16'h00F0, 16'h0010, 1, 0);
    run16(16'h5555, 16'h5555, 0, 1);

    // R8: pseudo-random walk on the 16-bit instance.
    begin
      logic [31:0] lf = 32'hACE1_2468;
      for (int n = 0; n < 2000; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        run16(int'(lf[15:0]), int'(lf[31:16]), int'(lf[3]), int'(lf[9]));
      end
    end

    // R8: exhaustive sweep of the 8-bit instance, both modes, both carry_in.
    for (int s = 0; s < 2; s++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b++) begin
            int exp_r, exp_c, sr, exp_o, sa, sb;
            a8 = a[7:0]; b8 = b[7:0]; ci8 = ci[0]; s8 = s[0];
            #1;
            sa = (a >= 128) ? a - 256 : a;
            sb = (b >= 128) ? b - 256 : b;
            if (s != 0) begin
              exp_r = (a - b) & 8'hFF;
              exp_c = (a >= b) ? 1 : 0;
              sr = sa - sb;
            end else begin
              exp_r = (a + b + ci) & 8'hFF;
              exp_c = (a + b + ci) >> 8;
              sr = sa + sb + ci;
            end
            exp_o = (sr > 127 || sr < -128) ? 1 : 0;
            checks++;
            if (r8 != exp_r[7:0] || co8 != exp_c[0] || ov8 != exp_o[0]) begin
              fails++;
              $display("FAIL %s a=%0h b=%0h ci=%0d actual=%0h/%0d/%0d expected=%0h/%0d/%0d",
                       (s != 0) ? "R8 R3 R4 R5 sweep8" : "R8 R1 R5 sweep8",
                       a, b, ci, r8, co8, ov8, exp_r, exp_c, exp_o);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule